// File: doc/BRIEF.md
# Hot-plug slot command controller

This block holds the slot control word and the slot status word of a downstream port that can be hot-plugged, both reached through configuration writes and combinational reads. It decides whether a write to the slot control word counts as a hot-plug command. It passes each accepted command to an external slot-signal expander over a request/acknowledge pair. It reports delivery through a command-completed status flag. Software clears that flag by writing a one to it.

Two straps shape the behaviour. `strap_hp_capable` low means the port cannot be hot-plugged, and then no write ever becomes a command. `strap_change_only` picks the detection rule. When it is low, every write to the slot control word is a command. When it is high, a write is a command only when it changes the six-bit control field. That field holds attention indicator, power indicator, power controller and interlock control. A write that touches only the notification-enable bits then never raises the flag.

Delivery runs in a three-state machine. IDLE goes to SEND when a command is accepted. SEND stays put until `exp_ack`. On `exp_ack`, SEND goes to GAP if a newer command is waiting, and to IDLE otherwise. GAP always goes back to SEND, carrying the most recent control value.

Top module: `hp_slot_cmd_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the slot control word (offset 0xA8) becomes 0x0000, the flag (bit 4 of the status word at offset 0xAA) becomes 0, and `exp_req` becomes 0.
- R2: Every write to offset 0xA8 stores all 16 bits, and reads at 0xA8 return them, in every mode and for either capability strap.
- R3: With `strap_change_only` high, a write whose bits [11:6] equal the stored bits [11:6] raises no `exp_req` and never sets the flag. An example is a repeated 0x1038.
- R4: With `strap_change_only` high, a write that changes any of bits [11:6] raises `exp_req` in the cycle after the write. `exp_ctl` then equals the new bits [11:6].
- R5: With `strap_change_only` low, every write to 0xA8 is a command. This includes a write that repeats the stored value.
- R6: With `strap_hp_capable` low, no write raises `exp_req` or sets the flag.
- R7: `exp_req` and `exp_ctl` hold steady until `exp_ack`. The flag stays 0 before the acknowledge and reads 1 in the cycle after it.
- R8: The flag reads as bit 4 of offset 0xAA, and all other status bits read 0. Writing 1 to bit 4 clears the flag. Writing 0 leaves it unchanged.
- R9: If a flag clear and a new completion fall on the same clock edge, the flag ends up set.
- R10: Commands that arrive while a delivery is pending collapse into one waiting command that holds the newest control value. After the current acknowledge, `exp_req` is low for exactly one cycle and then rises again with that value.
- R11: Each delivered command sets the flag exactly once. Once the last acknowledge is in, `exp_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strap_hp_capable | input | 1 | Port can be hot-plugged |
| strap_change_only | input | 1 | 1: only a change to the control field is a command; 0: every write is a command |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Configuration byte offset |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data for `cfg_addr` |
| exp_req | output | 1 | Command request to the expander |
| exp_ctl | output | 6 | Control field carried with the request |
| exp_ack | input | 1 | Expander acknowledge |

## Verification
Two pairs of functions can fall on the same clock edge. The first pair is the flag's write-one-to-clear and the completion that follows an acknowledge. The bench drives `exp_ack` and a status write of 0x0010 in the same cycle, and the status word must then read 0x0010. The second pair is a new command arriving during a delivery and the acknowledge of the current one. Here the bench writes three control values before acknowledging. It then checks for a one-cycle gap in `exp_req`, followed by a second request that carries only the last value, and for no third request.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
    localparam int unsigned REG_W  = 16;
    localparam int unsigned FLD_LO = 6;
    localparam int unsigned FLD_HI = 11;
    localparam int unsigned CC_BIT = 4;

    typedef enum logic [1:0] {
        DLV_IDLE = 2'd0,
        DLV_SEND = 2'd1,
        DLV_GAP  = 2'd2
    } dlv_state_e;
endpackage

// File: rtl/hp_cmd_detect.sv
module hp_cmd_detect #(
    parameter int unsigned FLD_W = 6
) (
    input  logic             wr_ctl,
    input  logic             hp_capable,
    input  logic             change_only,
    input  logic [FLD_W-1:0] old_fld,
    input  logic [FLD_W-1:0] new_fld,
    output logic             cmd_fire
);
    logic fld_changed;

    always_comb begin
        fld_changed = (old_fld != new_fld);
        cmd_fire    = 1'b0;
        if (wr_ctl && hp_capable) begin
            cmd_fire = change_only ? fld_changed : 1'b1;
        end
    end
endmodule

// File: rtl/hp_cmd_deliver.sv
module hp_cmd_deliver
    import hp_slot_pkg::*;
#(
    parameter int unsigned FLD_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_fire,
    input  logic [FLD_W-1:0] cmd_fld,
    input  logic             exp_ack,
    output logic             exp_req,
    output logic [FLD_W-1:0] exp_ctl,
    output logic             done
);
    dlv_state_e       state_q, state_d;
    logic [FLD_W-1:0] send_q;
    logic [FLD_W-1:0] pend_q;
    logic             pend_v_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DLV_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DLV_IDLE: if (cmd_fire) state_d = DLV_SEND;
            DLV_SEND: if (exp_ack)  state_d = (pend_v_q || cmd_fire) ? DLV_GAP : DLV_IDLE;
            DLV_GAP:                state_d = DLV_SEND;
            default:                state_d = DLV_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        exp_req = (state_q == DLV_SEND);
        exp_ctl = send_q;
        done    = (state_q == DLV_SEND) && exp_ack;
    end

    // command value and waiting slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            send_q   <= '0;
            pend_q   <= '0;
            pend_v_q <= 1'b0;
        end else begin
            unique case (state_q)
                DLV_IDLE: if (cmd_fire) send_q <= cmd_fld;
                DLV_SEND: if (cmd_fire) begin
                    pend_q   <= cmd_fld;
                    pend_v_q <= 1'b1;
                end
                DLV_GAP: begin
                    send_q   <= cmd_fire ? cmd_fld : pend_q;
                    pend_v_q <= 1'b0;
                end
                default: pend_v_q <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/hp_cc_status.sv
module hp_cc_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic cc_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)     cc_o <= 1'b0;
        else if (set_i) cc_o <= 1'b1;
        else if (clr_i) cc_o <= 1'b0;
    end
endmodule

// File: rtl/hp_slot_cmd_ctrl.sv
module hp_slot_cmd_ctrl
    import hp_slot_pkg::*;
#(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned DATA_W  = REG_W,
    parameter logic [ADDR_W-1:0] CTL_OFS = 12'hA8,
    parameter logic [ADDR_W-1:0] STS_OFS = 12'hAA,
    parameter int unsigned F_LO    = FLD_LO,
    parameter int unsigned F_HI    = FLD_HI,
    parameter int unsigned CC_POS  = CC_BIT,
    localparam int unsigned FLD_W  = F_HI - F_LO + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_hp_capable,
    input  logic              strap_change_only,
    input  logic              cfg_wr_en,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              exp_req,
    output logic [FLD_W-1:0]  exp_ctl,
    input  logic              exp_ack
);
    logic [DATA_W-1:0] slot_ctl_q;
    logic              wr_ctl, wr_sts, cc_clr, cmd_fire, dlv_done, cc_q;

    assign wr_ctl = cfg_wr_en && (cfg_addr == CTL_OFS);
    assign wr_sts = cfg_wr_en && (cfg_addr == STS_OFS);
    assign cc_clr = wr_sts && cfg_wdata[CC_POS];

    always_ff @(posedge clk) begin
        if (!rst_n)      slot_ctl_q <= '0;
        else if (wr_ctl) slot_ctl_q <= cfg_wdata;
    end

    hp_cmd_detect #(.FLD_W(FLD_W)) u_detect (
        .wr_ctl      (wr_ctl),
        .hp_capable  (strap_hp_capable),
        .change_only (strap_change_only),
        .old_fld     (slot_ctl_q[F_HI:F_LO]),
        .new_fld     (cfg_wdata[F_HI:F_LO]),
        .cmd_fire    (cmd_fire)
    );

    hp_cmd_deliver #(.FLD_W(FLD_W)) u_deliver (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_fire (cmd_fire),
        .cmd_fld  (cfg_wdata[F_HI:F_LO]),
        .exp_ack  (exp_ack),
        .exp_req  (exp_req),
        .exp_ctl  (exp_ctl),
        .done     (dlv_done)
    );

    hp_cc_status u_cc (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (dlv_done),
        .clr_i (cc_clr),
        .cc_o  (cc_q)
    );

    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == CTL_OFS)      cfg_rdata = slot_ctl_q;
        else if (cfg_addr == STS_OFS) cfg_rdata[CC_POS] = cc_q;
    end
endmodule

// File: rtl/hp_slot_cmd_chk.sv
module hp_slot_cmd_chk #(
    parameter int unsigned FLD_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             strap_hp_capable,
    input logic             exp_req,
    input logic             exp_ack,
    input logic [FLD_W-1:0] exp_ctl,
    input logic             cc_q
);
    // R1: the request is low after any reset edge
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> !exp_req);

    // R7: request and field stay put until acknowledged
    a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        exp_req && !exp_ack |=> exp_req && $stable(exp_ctl));

    // R7 / R9: an acknowledge always leaves the flag set
    a_r9_ack_sets_cc: assert property (@(posedge clk) disable iff (!rst_n)
        exp_req && exp_ack |=> cc_q);

    // R11: the flag rises only right after an acknowledge
    a_r11_cc_rise_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cc_q) |-> $past(exp_req && exp_ack));

    // R10: one idle cycle follows each acknowledge
    a_r10_gap_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        exp_req && exp_ack |=> !exp_req);

    // R6: a port that cannot be hot-plugged starts no request
    a_r6_no_cmd_incapable: assert property (@(posedge clk) disable iff (!rst_n)
        !strap_hp_capable && !exp_req |=> !exp_req);
endmodule

bind hp_slot_cmd_ctrl hp_slot_cmd_chk #(.FLD_W(FLD_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .strap_hp_capable (strap_hp_capable),
    .exp_req          (exp_req),
    .exp_ack          (exp_ack),
    .exp_ctl          (exp_ctl),
    .cc_q             (cc_q)
);

// File: tb/test_hp_slot_cmd_ctrl.sv
module test_hp_slot_cmd_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] A_CTL = 12'hA8;
    localparam logic [11:0] A_STS = 12'hAA;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_hp_capable = 1'b1;
    logic        strap_change_only = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        exp_req;
    logic [5:0]  exp_ctl;
    logic        exp_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hp_slot_cmd_ctrl i_hp_slot_cmd_ctrl (
        .clk(clk), .rst_n(rst_n),
        .strap_hp_capable(strap_hp_capable), .strap_change_only(strap_change_only),
        .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .exp_req(exp_req), .exp_ctl(exp_ctl), .exp_ack(exp_ack)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic cfg_write(logic [11:0] a, logic [15:0] d);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic ack_pulse();
        exp_ack = 1'b1;
        @(negedge clk);
        exp_ack = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [15:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        rd(A_CTL, d); check("R1 ctl after reset", d, 16'h0000);
        rd(A_STS, d); check("R1 sts after reset", d, 16'h0000);
        check("R1 req after reset", 16'(exp_req), 16'h0);
    endtask

    task automatic t_legacy_same();
        logic [15:0] d;
        strap_change_only = 1'b1;
        cfg_write(A_CTL, 16'h0038);
        check("R3 no req on enable-only write", 16'(exp_req), 16'h0);
        rd(A_CTL, d); check("R2 ctl stored", d, 16'h0038);
        cfg_write(A_CTL, 16'h1038);
        cfg_write(A_CTL, 16'h1038);
        idle(2);
        check("R3 no req on repeated 0x1038", 16'(exp_req), 16'h0);
        rd(A_STS, d); check("R3 no completion", d, 16'h0000);
        rd(A_CTL, d); check("R2 ctl stored 0x1038", d, 16'h1038);
    endtask

    task automatic t_legacy_change();
        logic [15:0] d;
        cfg_write(A_CTL, 16'h0178);
        check("R4 req one cycle after change", 16'(exp_req), 16'h1);
        check("R4 ctl field", 16'(exp_ctl), 16'h0005);
        idle(3);
        check("R7 req held", 16'(exp_req), 16'h1);
        check("R7 ctl held", 16'(exp_ctl), 16'h0005);
        rd(A_STS, d); check("R7 no flag before ack", d, 16'h0000);
        ack_pulse();
        rd(A_STS, d); check("R7 flag after ack", d, 16'h0010);
        check("R7 req dropped", 16'(exp_req), 16'h0);
        cfg_write(A_STS, 16'hFFEF);
        rd(A_STS, d); check("R8 write 0 keeps flag", d, 16'h0010);
        cfg_write(A_STS, 16'h0010);
        rd(A_STS, d); check("R8 write 1 clears flag", d, 16'h0000);
    endtask

    task automatic t_compliant();
        logic [15:0] d;
        strap_change_only = 1'b0;
        cfg_write(A_CTL, 16'h0178);
        check("R5 repeat write is command", 16'(exp_req), 16'h1);
        check("R5 ctl field", 16'(exp_ctl), 16'h0005);
        ack_pulse();
        rd(A_STS, d); check("R5 completion", d, 16'h0010);
        cfg_write(A_STS, 16'h0010);
    endtask

    task automatic t_incapable();
        logic [15:0] d;
        strap_hp_capable = 1'b0;
        cfg_write(A_CTL, 16'h0E38);
        idle(3);
        check("R6 no req when incapable", 16'(exp_req), 16'h0);
        rd(A_STS, d); check("R6 no flag when incapable", d, 16'h0000);
        rd(A_CTL, d); check("R2 ctl stored when incapable", d, 16'h0E38);
        strap_hp_capable = 1'b1;
        strap_change_only = 1'b1;
    endtask

    task automatic t_pending();
        logic [15:0] d;
        cfg_write(A_CTL, 16'h0040);
        check("R4 first req", 16'(exp_req), 16'h1);
        cfg_write(A_CTL, 16'h0080);
        cfg_write(A_CTL, 16'h00C0);
        check("R10 ctl holds first value", 16'(exp_ctl), 16'h0001);
        ack_pulse();
        check("R10 gap after ack", 16'(exp_req), 16'h0);
        rd(A_STS, d); check("R11 first completion", d, 16'h0010);
        idle(1);
        check("R10 second req", 16'(exp_req), 16'h1);
        check("R10 newest value", 16'(exp_ctl), 16'h0003);
        cfg_write(A_STS, 16'h0010);
        rd(A_STS, d); check("R11 flag cleared mid delivery", d, 16'h0000);
        ack_pulse();
        rd(A_STS, d); check("R11 second completion", d, 16'h0010);
        idle(3);
        check("R11 no third req", 16'(exp_req), 16'h0);
        cfg_write(A_STS, 16'h0010);
    endtask

    task automatic t_set_wins();
        logic [15:0] d;
        cfg_write(A_CTL, 16'h0000);
        check("R4 req for set-wins case", 16'(exp_req), 16'h1);
        exp_ack = 1'b1; cfg_wr_en = 1'b1; cfg_addr = A_STS; cfg_wdata = 16'h0010;
        @(negedge clk);
        exp_ack = 1'b0; cfg_wr_en = 1'b0;
        rd(A_STS, d); check("R9 set wins over clear", d, 16'h0010);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        t_reset();
        t_legacy_same();
        t_legacy_change();
        t_compliant();
        t_incapable();
        t_pending();
        t_set_wins();
        rst_n = 1'b0;
        idle(1);
        rst_n = 1'b1;
        t_reset();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule